// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Controller

This block moves items between I/O devices and memory on behalf of the processor. It never holds the data: for each item it drives a memory address, the pair of read and write strobes for the chosen direction, and an acknowledge to the device. Memory and device then exchange the item directly. Each of the four channels has its own start address, item count and mode. Software loads these through a plain register-write port. A channel also has a mask bit, a sticky terminal-count flag and a pending-request indication.

A device asks for service by raising its request line. The controller picks the lowest-numbered channel that is ready and raises a hold request to the processor. It waits for hold acknowledge. It then runs items at one per clock for as long as the channel's mode allows. After that it drops hold request and waits for the processor to take hold acknowledge back before it starts any new service.

No data stream passes through the block, so it has no valid/ready port. Flow control has two sources. The processor holds off the block by delaying hold acknowledge. In demand mode a device pauses a run by lowering its request. The next item follows only after the request is seen again.

Top module: `dma_flyby_ctrl`

## Requirements
- R1: `hold_req` rises in the cycle after an eligible request is seen in idle. No item cycle (any `dev_ack` bit high) starts before `hold_ack` has been sampled high, and `hold_ack` stays high during item cycles.
- R2: During an item cycle exactly one `dev_ack` bit is high, the one of the channel being served. At all other times `dev_ack` is zero.
- R3: Mode bits 3:2 select the strobes for every item cycle. 01 drives `io_rd` with `mem_wr`. 10 drives `mem_rd` with `io_wr`. 00 (verify) and 11 drive no strobe.
- R4: Each item drives the channel's current address on `mem_addr`. The address then steps by one, upward when mode bit 5 is 0 and downward when it is 1. The count drops by one.
- R5: When the count reaches zero, the run ends, `hold_req` falls and the channel's `tc_stat` bit sets. Writing that channel's count clears the bit.
- R6: With mode bit 4 set, the current address and count reload from their programmed start values at terminal count.
- R7: Mode bits 7:6 = 01 (single) perform one item per grant. Hold is requested again while the device request stays high.
- R8: Mode bits 7:6 = 10 (block) run items back to back until terminal count, whatever the request line does after the start.
- R9: Mode bits 7:6 = 00 (demand) end the run after the first item whose following clock edge sees the request low. A later request resumes from the stepped address and count.
- R10: Among channels that request at once, the lowest-numbered channel is served first. A channel in mode 11 (cascade) or with a zero count is never served.
- R11: After reset all four channels are masked. Register 3 writes all mask bits from data bits 3:0. Register 4 sets (data bit 2 = 1) or clears (data bit 2 = 0) the mask of the channel in data bits 1:0. A masked channel is never served.
- R12: `req_stat` shows, per channel, the request line AND NOT its mask bit.
- R13: A mode write (register 2) goes to the channel named in data bits 1:0, not the channel on `cfg_chan`. Register 0 (address) and register 1 (count) go to `cfg_chan`.
- R14: After a run ends, `hold_req` stays low until `hold_ack` has been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_reg | input | 3 | Register select: 0 address, 1 count, 2 mode, 3 mask all, 4 mask one |
| cfg_chan | input | 2 | Target channel for address and count writes |
| cfg_wdata | input | AW | Write data |
| dev_req | input | NCH | Device request lines |
| dev_ack | output | NCH | Device acknowledge lines |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| mem_addr | output | AW | Memory address during item cycles, zero otherwise |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| tc_stat | output | NCH | Sticky terminal-count flags |
| req_stat | output | NCH | Pending unmasked requests |

## Verification
Most internal faults in this block show up at the pins within one item cycle. A mis-stepped current address appears on `mem_addr` in the channel's next item cycle. A wrong count shows as one acknowledge cycle too many or too few, and as a terminal flag that arrives early or late. A sequencer that leaves its state at the wrong time shows as `hold_req` rising while the grant is still held, or as single and demand runs running too long. Because the reference model is compared with every output on every clock, each of these faults is reported in the cycle where it first shows.

// File: rtl/dma_fb_pkg.sv
package dma_fb_pkg;

  typedef enum logic [1:0] {
    XK_DEMAND  = 2'd0,
    XK_SINGLE  = 2'd1,
    XK_BLOCK   = 2'd2,
    XK_CASCADE = 2'd3
  } xkind_e;

  typedef enum logic [1:0] {
    DIR_VERIFY = 2'd0,
    DIR_IO2MEM = 2'd1,
    DIR_MEM2IO = 2'd2,
    DIR_RSVD   = 2'd3
  } xdir_e;

  // byte as written by software; chan picks the target channel
  typedef struct packed {
    xkind_e     kind;
    logic       addr_down;
    logic       auto_init;
    xdir_e      dir;
    logic [1:0] chan;
  } mode_wr_t;

  // what a channel keeps
  typedef struct packed {
    xkind_e kind;
    logic   addr_down;
    logic   auto_init;
    xdir_e  dir;
  } chan_mode_t;

  typedef enum logic [2:0] {
    CFG_ADDR     = 3'd0,
    CFG_COUNT    = 3'd1,
    CFG_MODE     = 3'd2,
    CFG_MASK_ALL = 3'd3,
    CFG_MASK_ONE = 3'd4
  } cfg_reg_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_HOLD = 2'd1,
    SQ_XFER = 2'd2,
    SQ_DROP = 2'd3
  } seq_state_e;

endpackage

// File: rtl/dma_fb_chan.sv
module dma_fb_chan
  import dma_fb_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_addr,
  input  logic             wr_count,
  input  logic             wr_mode,
  input  logic [AW-1:0]    wdata,
  input  chan_mode_t       mode_in,
  input  logic             step,
  output logic [AW-1:0]    cur_addr,
  output logic [CW-1:0]    cur_cnt,
  output chan_mode_t       mode_q,
  output logic             tc_flag,
  output logic             last
);

  logic [AW-1:0] base_addr;
  logic [CW-1:0] base_cnt;
  logic [AW-1:0] next_addr;

  assign last      = (cur_cnt == CW'(1));
  assign next_addr = mode_q.addr_down ? cur_addr - AW'(1) : cur_addr + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode_q    <= '0;
      tc_flag   <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= mode_in;
      if (step) begin
        if (last) begin
          tc_flag <= 1'b1;
          if (mode_q.auto_init) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
          end else begin
            cur_addr <= next_addr;
            cur_cnt  <= '0;
          end
        end else begin
          cur_addr <= next_addr;
          cur_cnt  <= cur_cnt - CW'(1);
        end
      end else begin
        if (wr_addr) begin
          base_addr <= wdata;
          cur_addr  <= wdata;
        end
        if (wr_count) begin
          base_cnt <= CW'(wdata);
          cur_cnt  <= CW'(wdata);
          tc_flag  <= 1'b0;
        end
      end
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> (cur_cnt == CW'($past(cur_cnt) - CW'(1)))); // R4
  AST_TC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> tc_flag); // R5
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && mode_q.auto_init) |=> (cur_cnt == base_cnt && cur_addr == base_addr)); // R6
  AST_NO_RELOAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !mode_q.auto_init) |=> (cur_cnt == '0)); // R5

endmodule

// File: rtl/dma_fb_arb.sv
module dma_fb_arb #(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic [NCH-1:0] elig,
  output logic           any,
  output logic [CHW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) idx = CHW'(i);
    end
  end

  assign any = |elig;

endmodule

// File: rtl/dma_fb_seq.sv
module dma_fb_seq
  import dma_fb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold_ack,
  input  logic           any_elig,
  input  logic [CHW-1:0] win_idx,
  input  logic           req_sel,
  input  xkind_e         kind_sel,
  input  logic           last_sel,
  output seq_state_e     state_q,
  output logic [CHW-1:0] ch_q,
  output logic           hold_req,
  output logic           step
);

  logic run_ends;

  assign hold_req = (state_q == SQ_HOLD) || (state_q == SQ_XFER);
  assign step     = (state_q == SQ_XFER);
  assign run_ends = last_sel || (kind_sel == XK_SINGLE) ||
                    ((kind_sel == XK_DEMAND) && !req_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ch_q    <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (any_elig) begin
          state_q <= SQ_HOLD;
          ch_q    <= win_idx;
        end
        SQ_HOLD: if (hold_ack) state_q <= SQ_XFER;
        SQ_XFER: if (run_ends) state_q <= SQ_DROP;
        SQ_DROP: if (!hold_ack) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_GRANT_BEFORE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_HOLD && !hold_ack) |=> (state_q != SQ_XFER)); // R1
  AST_NO_REHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_DROP && hold_ack) |=> !hold_req); // R14
  AST_BLOCK_RUNS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_XFER && kind_sel == XK_BLOCK && !last_sel) |=> (state_q == SQ_XFER)); // R8
  AST_SINGLE_ONE_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_XFER && kind_sel == XK_SINGLE) |=> !hold_req); // R7

endmodule

// File: rtl/dma_flyby_ctrl.sv
module dma_flyby_ctrl
  import dma_fb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [2:0]               cfg_reg,
  input  logic [$clog2(NCH)-1:0]   cfg_chan,
  input  logic [AW-1:0]            cfg_wdata,
  input  logic [NCH-1:0]           dev_req,
  output logic [NCH-1:0]           dev_ack,
  output logic                     hold_req,
  input  logic                     hold_ack,
  output logic [AW-1:0]            mem_addr,
  output logic                     mem_rd,
  output logic                     mem_wr,
  output logic                     io_rd,
  output logic                     io_wr,
  output logic [NCH-1:0]           tc_stat,
  output logic [NCH-1:0]           req_stat
);

  localparam int CHW = $clog2(NCH);

  mode_wr_t   wr_mode_w;
  chan_mode_t wr_mode_keep;
  logic [NCH-1:0] mask_q;
  logic [NCH-1:0] elig;
  logic [NCH-1:0] ch_last;
  logic [AW-1:0]  ch_addr [NCH];
  logic [CW-1:0]  ch_cnt  [NCH];
  chan_mode_t     ch_mode [NCH];

  seq_state_e     state;
  logic [CHW-1:0] sel;
  logic           step;
  logic           any_elig;
  logic [CHW-1:0] win_idx;
  logic           xfer;
  xdir_e          dir_sel;

  assign wr_mode_w    = mode_wr_t'(cfg_wdata[7:0]);
  assign wr_mode_keep = '{kind: wr_mode_w.kind, addr_down: wr_mode_w.addr_down,
                          auto_init: wr_mode_w.auto_init, dir: wr_mode_w.dir};

  // mask register: all channels start masked
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (cfg_wr) begin
      if (cfg_reg == CFG_MASK_ALL) mask_q <= cfg_wdata[NCH-1:0];
      else if (cfg_reg == CFG_MASK_ONE) mask_q[cfg_wdata[CHW-1:0]] <= cfg_wdata[CHW];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_a, wr_c, wr_m, stp;
    assign wr_a = cfg_wr && (cfg_reg == CFG_ADDR)  && (cfg_chan == CHW'(i));
    assign wr_c = cfg_wr && (cfg_reg == CFG_COUNT) && (cfg_chan == CHW'(i));
    assign wr_m = cfg_wr && (cfg_reg == CFG_MODE)  && (wr_mode_w.chan == 2'(i));
    assign stp  = step && (sel == CHW'(i));

    dma_fb_chan #(.AW(AW), .CW(CW)) i_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_addr  (wr_a),
      .wr_count (wr_c),
      .wr_mode  (wr_m),
      .wdata    (cfg_wdata),
      .mode_in  (wr_mode_keep),
      .step     (stp),
      .cur_addr (ch_addr[i]),
      .cur_cnt  (ch_cnt[i]),
      .mode_q   (ch_mode[i]),
      .tc_flag  (tc_stat[i]),
      .last     (ch_last[i])
    );

    assign elig[i] = dev_req[i] && !mask_q[i] && (ch_cnt[i] != '0) &&
                     (ch_mode[i].kind != XK_CASCADE);
  end

  dma_fb_arb #(.NCH(NCH)) i_arb (
    .elig (elig),
    .any  (any_elig),
    .idx  (win_idx)
  );

  dma_fb_seq #(.NCH(NCH)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_ack (hold_ack),
    .any_elig (any_elig),
    .win_idx  (win_idx),
    .req_sel  (dev_req[sel]),
    .kind_sel (ch_mode[sel].kind),
    .last_sel (ch_last[sel]),
    .state_q  (state),
    .ch_q     (sel),
    .hold_req (hold_req),
    .step     (step)
  );

  assign xfer     = (state == SQ_XFER);
  assign dir_sel  = ch_mode[sel].dir;
  assign dev_ack  = xfer ? (NCH'(1) << sel) : '0;
  assign mem_addr = xfer ? ch_addr[sel] : '0;
  assign mem_rd   = xfer && (dir_sel == DIR_MEM2IO);
  assign io_wr    = xfer && (dir_sel == DIR_MEM2IO);
  assign io_rd    = xfer && (dir_sel == DIR_IO2MEM);
  assign mem_wr   = xfer && (dir_sel == DIR_IO2MEM);
  assign req_stat = dev_req & ~mask_q;

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack)); // R2
  AST_ACK_UNDER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (|dev_ack) |-> hold_ack); // R1
  AST_STROBE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || io_rd || io_wr) |-> (|dev_ack)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && io_rd) && !(mem_wr && io_wr) && !(mem_rd && mem_wr)); // R3
  AST_MASKED_NOT_STARTED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_IDLE && any_elig) |-> !mask_q[win_idx]); // R11
  AST_ADDR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && $past(xfer) && sel == $past(sel) && !$past(ch_last[sel]))
      |-> (mem_addr == ($past(ch_mode[sel].addr_down) ? $past(mem_addr) - AW'(1)
                                                     : $past(mem_addr) + AW'(1)))); // R4

endmodule

// File: tb/test_dma_flyby_ctrl.sv
module test_dma_flyby_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_reg = '0;
  logic [1:0]  cfg_chan = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  dev_req = '0;
  logic [3:0]  dev_ack;
  logic        hold_req;
  logic        hold_ack = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr;
  logic [3:0]  tc_stat, req_stat;

  always #2 clk = ~clk;

  dma_flyby_ctrl i_dma_flyby_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_reg(cfg_reg),
    .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata), .dev_req(dev_req),
    .dev_ack(dev_ack), .hold_req(hold_req), .hold_ack(hold_ack),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .tc_stat(tc_stat), .req_stat(req_stat)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // processor: grants one cycle after request, releases three cycles after drop
  int rel_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      hold_ack <= 1'b0;
      rel_cnt  <= 0;
    end else if (hold_req) begin
      hold_ack <= 1'b1;
      rel_cnt  <= 0;
    end else if (hold_ack) begin
      if (rel_cnt == 2) hold_ack <= 1'b0;
      else rel_cnt <= rel_cnt + 1;
    end
  end

  // reference model
  int m_st = 0;
  int m_ch = 0;
  int ba[4], ca[4], bc[4], cc[4];
  logic [7:0] md[4];
  logic [3:0] mk = 4'hF;
  logic [3:0] mtc = 4'h0;

  always @(posedge clk) begin
    int stepped;
    if (!rst_n) begin
      m_st = 0; m_ch = 0; mk = 4'hF; mtc = 4'h0;
      for (int i = 0; i < 4; i++) begin
        ba[i] = 0; ca[i] = 0; bc[i] = 0; cc[i] = 0; md[i] = 8'h00;
      end
    end else begin
      stepped = -1;
      case (m_st)
        0: begin
          for (int i = 3; i >= 0; i--)
            if (dev_req[i] && !mk[i] && cc[i] != 0 && md[i][7:6] != 2'd3) begin
              m_st = 1; m_ch = i;
            end
        end
        1: if (hold_ack) m_st = 2;
        2: begin
          int kind;
          bit lst;
          kind = md[m_ch][7:6];
          lst = (cc[m_ch] == 1);
          stepped = m_ch;
          if (lst) begin
            mtc[m_ch] = 1'b1;
            if (md[m_ch][4]) begin
              ca[m_ch] = ba[m_ch]; cc[m_ch] = bc[m_ch];
            end else begin
              ca[m_ch] = md[m_ch][5] ? ((ca[m_ch] - 1) & 16'hFFFF) : ((ca[m_ch] + 1) & 16'hFFFF);
              cc[m_ch] = 0;
            end
          end else begin
            ca[m_ch] = md[m_ch][5] ? ((ca[m_ch] - 1) & 16'hFFFF) : ((ca[m_ch] + 1) & 16'hFFFF);
            cc[m_ch] = cc[m_ch] - 1;
          end
          if (lst || kind == 1 || (kind == 0 && !dev_req[m_ch])) m_st = 3;
        end
        default: if (!hold_ack) m_st = 0;
      endcase
      if (cfg_wr) begin
        case (cfg_reg)
          3'd0: if (stepped != cfg_chan) begin ba[cfg_chan] = cfg_wdata; ca[cfg_chan] = cfg_wdata; end
          3'd1: if (stepped != cfg_chan) begin
                  bc[cfg_chan] = cfg_wdata; cc[cfg_chan] = cfg_wdata; mtc[cfg_chan] = 1'b0;
                end
          3'd2: md[cfg_wdata[1:0]] = cfg_wdata[7:0];
          3'd3: mk = cfg_wdata[3:0];
          3'd4: mk[cfg_wdata[1:0]] = cfg_wdata[2];
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison and observation counters
  int items[4];
  int rises = 0;
  int iord_cnt = 0, memrd_cnt = 0, strobe_cnt = 0;
  int first_ack = -1;
  int last_addr[4];
  int q3[$];
  logic prev_hold = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] e_ack;
      logic [1:0] e_dir;
      bit x;
      x = (m_st == 2);
      e_ack = x ? (4'b1 << m_ch) : 4'b0;
      e_dir = md[m_ch][3:2];
      chk("R1 hold_req", hold_req, (m_st == 1 || m_st == 2));
      chk("R2 dev_ack", dev_ack, e_ack);
      chk("R3 mem_rd", mem_rd, x && e_dir == 2'd2);
      chk("R3 io_wr", io_wr, x && e_dir == 2'd2);
      chk("R3 io_rd", io_rd, x && e_dir == 2'd1);
      chk("R3 mem_wr", mem_wr, x && e_dir == 2'd1);
      chk("R4 mem_addr", mem_addr, x ? ca[m_ch] : 0);
      chk("R5 tc_stat", tc_stat, mtc);
      chk("R12 req_stat", req_stat, dev_req & ~mk);
      if (hold_req && !prev_hold) begin
        rises++;
        chk("R14 rehold while granted", hold_ack, 1'b0);
      end
      prev_hold = hold_req;
      for (int i = 0; i < 4; i++)
        if (dev_ack[i]) begin
          items[i]++;
          last_addr[i] = mem_addr;
          if (first_ack < 0) first_ack = i;
          if (i == 3) q3.push_back(mem_addr);
        end
      if (io_rd) iord_cnt++;
      if (mem_rd) memrd_cnt++;
      if (mem_rd || mem_wr || io_rd || io_wr) strobe_cnt++;
    end
  end

  task automatic wr(input logic [2:0] r, input logic [1:0] ch, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_reg = r; cfg_chan = ch; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_obs();
    for (int i = 0; i < 4; i++) items[i] = 0;
    rises = 0; iord_cnt = 0; memrd_cnt = 0; strobe_cnt = 0; first_ack = -1;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    clear_obs();
    // R11: masked at reset, requests do nothing
    dev_req = 4'hF;
    idle(8);
    @(negedge clk);
    chk("R11 reset hold_req", hold_req, 1'b0);
    chk("R12 reset req_stat", req_stat, 4'h0);
    chk("R5 reset tc_stat", tc_stat, 4'h0);
    chk("R11 no items while masked", items[0] + items[1] + items[2] + items[3], 0);
    dev_req = 4'h0;

    // S1: ch0 block mem->io, up, count 5
    wr(3'd0, 2'd0, 16'h0100);
    wr(3'd1, 2'd0, 16'd5);
    wr(3'd2, 2'd0, 16'h0088);
    wr(3'd3, 2'd0, 16'h0000);
    clear_obs();
    dev_req[0] = 1'b1; idle(1); dev_req[0] = 1'b0;
    idle(25);
    chk("R8 block item count", items[0], 5);
    chk("R3 mem_rd per item", memrd_cnt, 5);
    chk("R4 last up address", last_addr[0], 16'h0104);
    chk("R5 tc after block", tc_stat[0], 1'b1);
    chk("R1 one hold for block", rises, 1);

    // S2: ch1 single io->mem, down, count 3; mode routed by data bits 1:0
    wr(3'd0, 2'd1, 16'h0200);
    wr(3'd1, 2'd1, 16'd3);
    wr(3'd2, 2'd3, 16'h0065);
    clear_obs();
    dev_req[1] = 1'b1;
    idle(40);
    dev_req[1] = 1'b0;
    chk("R7 single holds per item", rises, 3);
    chk("R13 mode reached ch1", items[1], 3);
    chk("R3 io_rd per item", iord_cnt, 3);
    chk("R4 last down address", last_addr[1], 16'h01FE);

    // S3: ch2 demand verify, count 6, pause then resume
    wr(3'd0, 2'd2, 16'h0300);
    wr(3'd1, 2'd2, 16'd6);
    wr(3'd2, 2'd0, 16'h0002);
    clear_obs();
    dev_req[2] = 1'b1;
    while (items[2] < 2) @(negedge clk);
    @(posedge clk); #1;
    dev_req[2] = 1'b0;
    idle(12);
    chk("R9 demand paused early", (items[2] >= 2 && items[2] < 6), 1'b1);
    chk("R9 no tc while paused", tc_stat[2], 1'b0);
    dev_req[2] = 1'b1;
    idle(20);
    dev_req[2] = 1'b0;
    chk("R9 demand total", items[2], 6);
    chk("R3 verify no strobes", strobe_cnt, 0);
    chk("R9 tc after resume", tc_stat[2], 1'b1);

    // S4: priority and cascade
    wr(3'd0, 2'd0, 16'h0010);
    wr(3'd1, 2'd0, 16'd2);
    wr(3'd0, 2'd3, 16'h0030);
    wr(3'd1, 2'd3, 16'd2);
    wr(3'd2, 2'd0, 16'h008B);
    wr(3'd1, 2'd1, 16'd4);
    wr(3'd2, 2'd0, 16'h00C9);
    clear_obs();
    dev_req = 4'b1011;
    idle(40);
    dev_req = 4'b0000;
    chk("R10 lowest first", first_ack, 0);
    chk("R10 cascade never served", items[1], 0);
    chk("R10 ch3 served after", items[3], 2);

    // S5: ch3 block, io->mem, auto-init, count 2
    wr(3'd0, 2'd3, 16'h0400);
    wr(3'd1, 2'd3, 16'd2);
    wr(3'd2, 2'd0, 16'h0097);
    q3.delete();
    dev_req[3] = 1'b1; idle(1); dev_req[3] = 1'b0;
    idle(20);
    chk("R6 tc with auto-init", tc_stat[3], 1'b1);
    dev_req[3] = 1'b1; idle(1); dev_req[3] = 1'b0;
    idle(20);
    chk("R6 second run length", q3.size(), 4);
    if (q3.size() == 4) begin
      chk("R6 reload address", q3[2], 16'h0400);
      chk("R6 second step", q3[3], 16'h0401);
    end

    // S6: single-channel mask set/clear on ch0
    wr(3'd4, 2'd0, 16'h0004);
    wr(3'd1, 2'd0, 16'd2);
    chk("R5 tc cleared by count write", tc_stat[0], 1'b0);
    clear_obs();
    dev_req[0] = 1'b1;
    idle(15);
    @(negedge clk);
    chk("R11 masked channel idle", items[0], 0);
    chk("R12 masked not pending", req_stat[0], 1'b0);
    wr(3'd4, 2'd0, 16'h0000);
    @(negedge clk);
    chk("R12 unmasked pending", req_stat[0], 1'b1);
    idle(20);
    dev_req[0] = 1'b0;
    chk("R11 unmasked served", items[0], 2);

    idle(10);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule